// File: doc/BRIEF.md
# Bit-Field and Byte-Shuffle Execution Unit

This block is the combinational datapath for a group of 32-bit register-to-register special operations. It is given two source operands, two 5-bit instruction fields, a 2-bit byte-position field and an operation group select. It returns a result word, a flag that selects which register the result is written to, and a flag that marks an encoding the unit does not implement.

Three operations are supported. Bit-field extract pulls a contiguous field out of the first operand and right-aligns it. Per-byte bit reversal mirrors the bit order inside every byte of the second operand and leaves each byte in its own lane. Byte align joins the two operands as a funnel at byte granularity. The sign-extension and halfword byte-swap encodings of the same group are not implemented here and are reported as illegal. A valid strobe passes straight through in the same cycle, so a checker can compare every result with a model.

Top module: `bfx_shuffle_alu`

## Requirements
- R1: With `grp_sel`=1 and `sa_fld`=0, `result` is `rt_val` with the bits of each byte reversed in place (bit 8k+i of the result is bit 8k+7-i of `rt_val`). No byte changes lane.
- R2: With `grp_sel`=1, `sa_fld[4:2]`=3'b010 and `bpos`=0, `result` equals `rt_val`.
- R3: With `grp_sel`=1, `sa_fld[4:2]`=3'b010 and `bpos`=b≠0, `result` = (`rt_val` << 8b) | (`rs_val` >> 8(4−b)), using logical shifts.
- R4: Align is selected by `sa_fld[4:2]`=3'b010 alone. The shift comes from `bpos`, and `sa_fld[1:0]` has no effect on the result.
- R5: With `grp_sel`=0, `result` = (`rs_val` >> lsb) & mask, where lsb is `sa_fld`, msb is `rd_fld`, and mask holds msb+1 ones. Bits of the field above bit 31 read as 0.
- R6: A field size of 32 (`rd_fld`=31) gives an all-ones mask, so with `sa_fld`=0 the result equals `rs_val`.
- R7: `dest_rd` is 0 for extract (result goes to rt) and 1 for bit reversal and align (result goes to rd).
- R8: `illegal_op`=1, `result`=0 and `dest_rd`=0 for `grp_sel` of 2 or 3, and for any `grp_sel`=1 sub-code other than 0 or 3'b010xx. This includes 5'b10000, 5'b11000 and 5'b00010.
- R9: `valid_out` equals `valid_in` in the same cycle, and `valid_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_in | input | 1 | Operand-valid strobe |
| grp_sel | input | 2 | Operation group: 0 extract, 1 byte-shuffle group |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| rd_fld | input | 5 | rd field; field msb for extract |
| sa_fld | input | 5 | sa field; lsb for extract, sub-code for the shuffle group |
| bpos | input | 2 | Byte position for align |
| valid_out | output | 1 | Same-cycle copy of valid_in |
| result | output | 32 | Operation result |
| dest_rd | output | 1 | 1: write rd, 0: write rt |
| illegal_op | output | 1 | Unsupported encoding |

## Verification
The bench drives full-width extracts (msb 31), where a mask built as 1<<32 wraps and yields zero or garbage. It also drives fields that run past bit 31, which a mask shifted left before the shift down would corrupt. Align runs at every byte position, including zero, where a naive rs>>32 leaks rs into the result. Nonzero values are placed in `sa_fld[1:0]` to catch a decoder that reads the shift from the wrong bits. The unsupported sub-codes, which sit close to the valid ones, are driven to expose a decoder that lets them fall through to bit reversal.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [1:0] {
    GRP_EXTRACT = 2'd0,
    GRP_SHUFFLE = 2'd1
  } grp_e;

  typedef enum logic [1:0] {
    UNIT_NONE  = 2'd0,
    UNIT_EXT   = 2'd1,
    UNIT_SWAP  = 2'd2,
    UNIT_ALIGN = 2'd3
  } unit_e;

  localparam logic [4:0] SUB_BITREV    = 5'b00000;
  localparam logic [2:0] SUB_ALIGN_TOP = 3'b010;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [1:0] grp_sel,
  input  logic [4:0] sa_fld,
  output unit_e      unit
);
  always_comb begin
    unit = UNIT_NONE;
    if (grp_sel == GRP_EXTRACT) begin
      unit = UNIT_EXT;
    end else if (grp_sel == GRP_SHUFFLE) begin
      if (sa_fld == SUB_BITREV)
        unit = UNIT_SWAP;
      else if (sa_fld[4:2] == SUB_ALIGN_TOP)
        unit = UNIT_ALIGN;
    end
  end
endmodule

// File: rtl/bfx_bitrev.sv
module bfx_bitrev #(
  parameter int W    = 32,
  parameter int BYTE = 8
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  localparam int NB = W / BYTE;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE-1:0] lane_in;
    logic [BYTE-1:0] lane_out;
    assign lane_in = src[b*BYTE +: BYTE];
    for (genvar i = 0; i < BYTE; i++) begin : g_bit
      assign lane_out[i] = lane_in[BYTE-1-i];
    end
    assign dst[b*BYTE +: BYTE] = lane_out;

    always_comb begin
      AST_LANE_POPCOUNT: assert ($countones(lane_out) == $countones(lane_in))
        else $error("bit reversal moved bits across lanes"); // R1
    end
  end
endmodule

// File: rtl/bfx_align.sv
module bfx_align #(
  parameter int W    = 32,
  parameter int BYTE = 8
) (
  input  logic [W-1:0]                    hi_src,
  input  logic [W-1:0]                    lo_src,
  input  logic [$clog2(W/BYTE)-1:0]       bpos,
  output logic [W-1:0]                    dst
);
  localparam int DW = 2 * W;
  localparam int SW = $clog2(DW);

  logic [DW-1:0] joined;
  logic [DW-1:0] shifted;
  logic [SW-1:0] amt;

  always_comb begin
    joined  = {hi_src, lo_src};
    amt     = SW'(bpos) * SW'(BYTE);
    shifted = joined << amt;
    dst     = shifted[DW-1:W];
  end

  always_comb begin
    if (bpos == '0) begin
      AST_ALIGN_ZERO: assert (dst == hi_src)
        else $error("align with zero position altered rt"); // R2
    end else begin
      AST_ALIGN_UPPER: assert ((dst >> amt) == ((hi_src << amt) >> amt))
        else $error("align upper part is not rt"); // R3
    end
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int W = 32
) (
  input  logic [W-1:0]         src,
  input  logic [$clog2(W)-1:0] msb,
  input  logic [$clog2(W)-1:0] lsb,
  output logic [W-1:0]         dst
);
  localparam int PW = $clog2(W);
  localparam int SZW = PW + 1;

  logic [SZW-1:0] size;
  logic [W-1:0]   mask;

  always_comb begin
    size = SZW'(msb) + SZW'(1);
    mask = {W{1'b1}} >> (SZW'(W) - size);
    dst  = (src >> lsb) & mask;
  end

  always_comb begin
    if (size < SZW'(W)) begin
      AST_FIELD_CLEAN: assert ((dst >> size) == '0)
        else $error("extract left bits above the field"); // R5
    end
    if (msb == PW'(W - 1) && lsb == '0) begin
      AST_FULL_FIELD: assert (dst == src)
        else $error("full-width extract lost bits"); // R6
    end
  end
endmodule

// File: rtl/bfx_shuffle_alu.sv
module bfx_shuffle_alu
  import bfx_pkg::*;
#(
  parameter int W    = 32,
  parameter int BYTE = 8
) (
  input  logic                       valid_in,
  input  logic [1:0]                 grp_sel,
  input  logic [W-1:0]               rs_val,
  input  logic [W-1:0]               rt_val,
  input  logic [$clog2(W)-1:0]       rd_fld,
  input  logic [$clog2(W)-1:0]       sa_fld,
  input  logic [$clog2(W/BYTE)-1:0]  bpos,
  output logic                       valid_out,
  output logic [W-1:0]               result,
  output logic                       dest_rd,
  output logic                       illegal_op
);
  unit_e        unit;
  logic [W-1:0] swap_res;
  logic [W-1:0] align_res;
  logic [W-1:0] ext_res;

  bfx_decode u_dec (
    .grp_sel (grp_sel),
    .sa_fld  (sa_fld),
    .unit    (unit)
  );

  bfx_bitrev #(.W(W), .BYTE(BYTE)) u_rev (
    .src (rt_val),
    .dst (swap_res)
  );

  bfx_align #(.W(W), .BYTE(BYTE)) u_aln (
    .hi_src (rt_val),
    .lo_src (rs_val),
    .bpos   (bpos),
    .dst    (align_res)
  );

  bfx_extract #(.W(W)) u_ext (
    .src (rs_val),
    .msb (rd_fld),
    .lsb (sa_fld),
    .dst (ext_res)
  );

  always_comb begin
    result     = '0;
    dest_rd    = 1'b0;
    illegal_op = 1'b0;
    unique case (unit)
      UNIT_EXT:   result = ext_res;
      UNIT_SWAP:  begin result = swap_res;  dest_rd = 1'b1; end
      UNIT_ALIGN: begin result = align_res; dest_rd = 1'b1; end
      default:    illegal_op = 1'b1;
    endcase
    valid_out = valid_in;
  end

  always_comb begin
    if (illegal_op) begin
      AST_ILLEGAL_QUIET: assert (result == '0 && !dest_rd)
        else $error("illegal encoding produced output"); // R8
    end
    if (grp_sel == GRP_EXTRACT) begin
      AST_EXTRACT_TO_RT: assert (!dest_rd && !illegal_op)
        else $error("extract routed wrongly"); // R7
    end
  end
endmodule

// File: tb/tb_bfx_shuffle_alu.sv
module tb_bfx_shuffle_alu;
  logic        clk;
  logic        rst_n;
  logic        valid_in;
  logic [1:0]  grp_sel;
  logic [31:0] rs_val, rt_val;
  logic [4:0]  rd_fld, sa_fld;
  logic [1:0]  bpos;
  logic        valid_out, dest_rd, illegal_op;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bfx_shuffle_alu dut (
    .valid_in(valid_in), .grp_sel(grp_sel), .rs_val(rs_val), .rt_val(rt_val),
    .rd_fld(rd_fld), .sa_fld(sa_fld), .bpos(bpos), .valid_out(valid_out),
    .result(result), .dest_rd(dest_rd), .illegal_op(illegal_op)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] ref_rev(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++)
        r[8*b+i] = v[8*b+7-i];
    return r;
  endfunction

  function automatic logic [31:0] ref_align(input logic [31:0] s, input logic [31:0] t,
                                            input logic [1:0] p);
    if (p == 2'd0) return t;
    return (t << (8*p)) | (s >> (8*(4-p)));
  endfunction

  function automatic logic [31:0] ref_ext(input logic [31:0] s, input logic [4:0] m,
                                          input logic [4:0] l);
    logic [31:0] r = '0;
    for (int i = 0; i <= int'(m); i++)
      if (int'(l) + i < 32) r[i] = s[int'(l) + i];
    return r;
  endfunction

  // returns {illegal, dest_rd, result}
  function automatic logic [33:0] ref_all(input logic [1:0] g, input logic [4:0] sa,
      input logic [4:0] rd, input logic [1:0] p, input logic [31:0] s, input logic [31:0] t);
    if (g == 2'd0) return {1'b0, 1'b0, ref_ext(s, rd, sa)};
    if (g == 2'd1 && sa == 5'd0) return {1'b0, 1'b1, ref_rev(t)};
    if (g == 2'd1 && sa[4:2] == 3'b010) return {1'b0, 1'b1, ref_align(s, t, p)};
    return {1'b1, 1'b0, 32'd0};
  endfunction

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got ill=%0b dst=%0b res=%08h expected ill=%0b dst=%0b res=%08h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] g, input logic [4:0] sa,
      input logic [4:0] rd, input logic [1:0] p, input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    grp_sel = g; sa_fld = sa; rd_fld = rd; bpos = p; rs_val = s; rt_val = t;
    valid_in = ~valid_in;
    #1;
    check(tag, {illegal_op, dest_rd, result}, ref_all(g, sa, rd, p, s, t));
    checks++;
    if (valid_out !== valid_in) begin
      errors++;
      $display("FAIL R9: valid_out=%0b expected %0b", valid_out, valid_in);
    end
  endtask

  function automatic string tag_of(input logic [1:0] g, input logic [4:0] sa, input logic [1:0] p);
    if (g == 2'd0) return "R5/R7 extract";
    if (g == 2'd1 && sa == 5'd0) return "R1/R7 bitrev";
    if (g == 2'd1 && sa[4:2] == 3'b010) return (p == 0) ? "R2/R4 align" : "R3/R4 align";
    return "R8 illegal";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, t, hold;
    logic [1:0]  g, p;
    logic [4:0]  sa, rd;
    void'($urandom(32'd1234));
    rst_n = 1'b0; valid_in = 1'b0; grp_sel = 2'd2; sa_fld = '0; rd_fld = '0;
    bpos = '0; rs_val = '0; rt_val = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (valid_out !== 1'b0 || illegal_op !== 1'b1 || result !== '0) begin
      errors++;
      $display("FAIL R9 reset: valid_out=%0b ill=%0b res=%08h expected 0 1 0",
               valid_out, illegal_op, result);
    end
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    apply("R1 bitrev lanes", 2'd1, 5'd0, 5'd3, 2'd2, 32'hFFFF_FFFF, 32'h0180_F00F);
    apply("R1 bitrev single", 2'd1, 5'd0, 5'd0, 2'd0, 32'h0, 32'h0000_0001);
    apply("R2 align zero", 2'd1, 5'b01000, 5'd0, 2'd0, 32'hDEAD_BEEF, 32'h1234_5678);
    apply("R3 align 1", 2'd1, 5'b01000, 5'd0, 2'd1, 32'hAABB_CCDD, 32'h1122_3344);
    apply("R3 align 2", 2'd1, 5'b01000, 5'd0, 2'd2, 32'hAABB_CCDD, 32'h1122_3344);
    apply("R3 align 3", 2'd1, 5'b01000, 5'd0, 2'd3, 32'hAABB_CCDD, 32'h1122_3344);
    apply("R4 align sa low bits", 2'd1, 5'b01011, 5'd0, 2'd1, 32'hAABB_CCDD, 32'h1122_3344);
    apply("R4 align sa low bits 2", 2'd1, 5'b01001, 5'd0, 2'd0, 32'hAABB_CCDD, 32'h1122_3344);
    apply("R6 full field", 2'd0, 5'd0, 5'd31, 2'd0, 32'h8765_4321, 32'h0);
    apply("R6 full field shifted", 2'd0, 5'd8, 5'd31, 2'd0, 32'h8765_4321, 32'h0);
    apply("R5 one bit top", 2'd0, 5'd31, 5'd0, 2'd0, 32'h8000_0000, 32'h0);
    apply("R5 field past top", 2'd0, 5'd28, 5'd7, 2'd0, 32'hF000_0000, 32'h0);
    apply("R5 mid field", 2'd0, 5'd4, 5'd7, 2'd0, 32'h0000_0AB0, 32'hFFFF_FFFF);
    apply("R8 seb code", 2'd1, 5'b10000, 5'd0, 2'd0, 32'h1, 32'h80);
    apply("R8 seh code", 2'd1, 5'b11000, 5'd0, 2'd0, 32'h1, 32'h8000);
    apply("R8 wsbh code", 2'd1, 5'b00010, 5'd0, 2'd0, 32'h1, 32'h1234);
    apply("R8 group 2", 2'd2, 5'd0, 5'd0, 2'd0, 32'h5, 32'h6);
    apply("R8 group 3", 2'd3, 5'b01000, 5'd0, 2'd1, 32'h5, 32'h6);

    // R9: valid_in toggling must not change result
    @(negedge clk);
    grp_sel = 2'd1; sa_fld = 5'b01000; bpos = 2'd2; rs_val = 32'hCAFE_F00D; rt_val = 32'h0BAD_C0DE;
    valid_in = 1'b0; #1; hold = result;
    valid_in = 1'b1; #1;
    checks++;
    if (result !== hold || valid_out !== 1'b1) begin
      errors++;
      $display("FAIL R9 valid independence: res=%08h vo=%0b expected %08h 1", result, valid_out, hold);
    end

    // constrained random
    for (int n = 0; n < 600; n++) begin
      s = $urandom; t = $urandom; rd = 5'($urandom); p = 2'($urandom);
      case ($urandom % 6)
        0, 1: begin g = 2'd0; sa = 5'($urandom); end
        2:    begin g = 2'd1; sa = 5'd0; end
        3, 4: begin g = 2'd1; sa = {3'b010, 2'($urandom)}; end
        default: begin g = 2'($urandom); sa = 5'($urandom); end
      endcase
      apply(tag_of(g, sa, p), g, sa, rd, p, s, t);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule